// File: doc/BRIEF.md
# Packet-Aware Byte-to-Word Lane Packer

This block takes a stream of single bytes with a valid/ready handshake. Each byte comes with a flag that marks it as the final byte of a packet. The block collects consecutive bytes into a wider output word of several byte lanes. Each lane has its own strobe bit that says whether the lane holds a real byte. A word leaves the block when all of its lanes are filled. It also leaves as soon as a packet ends, so the tail of a packet never waits for bytes from the next packet. When a partial word leaves, the strobes mark exactly the lanes that were filled.

The output side also uses valid/ready. A finished word stays in a single output register until the consumer accepts it. While that word is waiting, the input stops taking bytes. The block runs at one byte per cycle whenever the consumer does not apply backpressure.

Top module: `lane_pack_up`

## Requirements
- R1: Lane 0 carries the first byte of a word and later bytes fill the higher lanes in arrival order. A word of LANES bytes is emitted with every strobe bit set. Lane k occupies bits [8k+7:8k] of the data output, and strobe bit k belongs to lane k.
- R2: The output last flag is 1 only on the word that contains the final byte of a packet.
- R3: When an accepted byte carries last and leaves the word unfilled, the word is emitted with only strobe bits 0 to n-1 set, where n is the number of bytes it holds. The word becomes valid in the cycle after that byte is accepted.
- R4: After a word that ends a packet, the next byte is placed in lane 0. Bytes from two packets never share a word.
- R5: While the output is valid and output ready is low, the data, strobes and last flag of the output stay unchanged, and the output stays valid.
- R6: Input ready is 0 exactly when an output word is held and output ready is 0.
- R7: Every data lane whose strobe bit is 0 reads as zero.
- R8: After reset the output is not valid and input ready is 1.
- R9: A packet of a single byte gives one word with only strobe bit 0 set and last set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block accepts the input byte |
| in_byte | input | BYTE_W | Input data byte |
| in_last | input | 1 | Input byte ends its packet |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | LANES*BYTE_W | Packed lanes, lane 0 in the low bits |
| out_strb | output | LANES | Per-lane valid strobes |
| out_last | output | 1 | Word holds the final byte of a packet |

## Verification
The first pass uses directed packets with no backpressure. A packet of exactly one word shows that full words pass through unchanged. Lengths of twice the word size show that words follow each other back to back. Single-byte packets and packets of three, five and seven bytes produce partial tails, and these show whether early flushing and the zero padding of unused lanes work. In the second pass the consumer stalls at pseudo-random points and the input has gaps, over many packet lengths. This pass separates correct holding and input blocking from designs that drop, duplicate or merge bytes. Every cycle is compared against a behavioural queue model.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_BYTE_W = 8;

   function automatic int unsigned idx_width(input int unsigned lanes);
      return (lanes < 2) ? 1 : $clog2(lanes);
   endfunction
endpackage

// File: rtl/lane_fill.sv
module lane_fill #(
   parameter int unsigned LANES  = lane_pack_pkg::DEF_LANES,
   parameter int unsigned BYTE_W = lane_pack_pkg::DEF_BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  logic [BYTE_W-1:0]         byte_in,
   input  logic                      last_in,
   output logic                      done,
   output logic [LANES*BYTE_W-1:0]   word,
   output logic [LANES-1:0]          strb
);
   localparam int unsigned IDX_W = lane_pack_pkg::idx_width(LANES);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

   logic [IDX_W-1:0] idx;

   assign done = take && ((idx == TOP_IDX) || last_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (done)  idx <= '0;
      else if (take)  idx <= idx + 1'b1;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(l);
      logic [BYTE_W-1:0] held;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            held <= '0;
         else if (done)                         held <= '0;
         else if (take && (idx == MY_IDX))      held <= byte_in;
      end

      always_comb begin
         if (MY_IDX < idx)        word[l*BYTE_W +: BYTE_W] = held;
         else if (MY_IDX == idx)  word[l*BYTE_W +: BYTE_W] = byte_in;
         else                     word[l*BYTE_W +: BYTE_W] = '0;
         strb[l] = (MY_IDX <= idx);
      end
   end
endmodule

// File: rtl/word_hold.sv
module word_hold #(
   parameter int unsigned LANES  = lane_pack_pkg::DEF_LANES,
   parameter int unsigned BYTE_W = lane_pack_pkg::DEF_BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [LANES*BYTE_W-1:0]   word_in,
   input  logic [LANES-1:0]          strb_in,
   input  logic                      last_in,
   input  logic                      sink_ready,
   output logic                      space,
   output logic                      valid,
   output logic [LANES*BYTE_W-1:0]   word_out,
   output logic [LANES-1:0]          strb_out,
   output logic                      last_out
);
   assign space = !valid || sink_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         word_out <= '0;
         strb_out <= '0;
         last_out <= 1'b0;
      end else if (load) begin
         valid    <= 1'b1;
         word_out <= word_in;
         strb_out <= strb_in;
         last_out <= last_in;
      end else if (sink_ready) begin
         valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/lane_pack_up.sv
module lane_pack_up #(
   parameter int unsigned LANES  = lane_pack_pkg::DEF_LANES,
   parameter int unsigned BYTE_W = lane_pack_pkg::DEF_BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [BYTE_W-1:0]         in_byte,
   input  logic                      in_last,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [LANES*BYTE_W-1:0]   out_data,
   output logic [LANES-1:0]          out_strb,
   output logic                      out_last
);
   if (LANES < 2) begin : g_bad_lanes
      $error("lane_pack_up: LANES must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("lane_pack_up: BYTE_W must be at least 1");
   end

   logic                    take;
   logic                    done;
   logic [LANES*BYTE_W-1:0] next_word;
   logic [LANES-1:0]        next_strb;
   logic                    space;

   assign in_ready = space;
   assign take     = in_valid && space;

   lane_fill #(.LANES(LANES), .BYTE_W(BYTE_W)) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .byte_in (in_byte),
      .last_in (in_last),
      .done    (done),
      .word    (next_word),
      .strb    (next_strb)
   );

   word_hold #(.LANES(LANES), .BYTE_W(BYTE_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (done),
      .word_in    (next_word),
      .strb_in    (next_strb),
      .last_in    (in_last),
      .sink_ready (out_ready),
      .space      (space),
      .valid      (out_valid),
      .word_out   (out_data),
      .strb_out   (out_strb),
      .last_out   (out_last)
   );
endmodule

// File: rtl/lane_pack_up_chk.sv
module lane_pack_up_chk #(
   parameter int unsigned LANES  = lane_pack_pkg::DEF_LANES,
   parameter int unsigned BYTE_W = lane_pack_pkg::DEF_BYTE_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic                    in_last,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANES*BYTE_W-1:0] out_data,
   input logic [LANES-1:0]        out_strb,
   input logic                    out_last
);
   logic [LANES*BYTE_W-1:0] lane_mask;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_mask[l*BYTE_W +: BYTE_W] = {BYTE_W{out_strb[l]}};
      end
   end

   AST_STRB_FROM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_strb[0] && ((out_strb & (out_strb + LANES'(1))) == '0))); // R3
   AST_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_strb == {LANES{1'b1}})); // R4
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_strb) && $stable(out_last))); // R5
   AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R6
   AST_OPEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready); // R6
   AST_ZERO_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data & ~lane_mask) == '0)); // R7
   AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last && !(out_valid && !out_ready)) |=> (out_valid && out_last)); // R2
endmodule

bind lane_pack_up lane_pack_up_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_strb  (out_strb),
   .out_last  (out_last)
);

// File: tb/test_lane_pack_up.sv
module test_lane_pack_up;
   localparam int LANES  = 4;
   localparam int BYTE_W = 8;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_ready;
   logic [BYTE_W-1:0]       in_byte = '0;
   logic                    in_last = 1'b0;
   logic                    out_valid;
   logic                    out_ready = 1'b0;
   logic [LANES*BYTE_W-1:0] out_data;
   logic [LANES-1:0]        out_strb;
   logic                    out_last;

   always #10 clk = ~clk;

   lane_pack_up #(.LANES(LANES), .BYTE_W(BYTE_W)) i_lane_pack_up (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_strb(out_strb), .out_last(out_last)
   );

   int total = 0;
   int bad   = 0;

   // stimulus queue: {last, byte}
   logic [BYTE_W:0] src_q[$];
   logic [BYTE_W-1:0] acc_q[$];

   logic                    m_vld = 1'b0;
   logic [LANES*BYTE_W-1:0] m_data = '0;
   logic [LANES-1:0]        m_strb = '0;
   logic                    m_last = 1'b0;
   logic                    took = 1'b0;
   logic [15:0]             lfsr = 16'hACE1;
   int                      seq = 0;

   // behavioural reference, one step per rising edge
   always @(posedge clk) begin
      logic rdy_before;
      if (!rst_n) begin
         m_vld = 1'b0;
         acc_q.delete();
         took = 1'b0;
      end else begin
         rdy_before = !m_vld || out_ready;
         took = in_valid && rdy_before;
         if (m_vld && out_ready) m_vld = 1'b0;
         if (took) begin
            acc_q.push_back(in_byte);
            if (acc_q.size() == LANES || in_last) begin
               m_data = '0;
               m_strb = '0;
               foreach (acc_q[k]) begin
                  m_data[k*BYTE_W +: BYTE_W] = acc_q[k];
                  m_strb[k] = 1'b1;
               end
               m_last = in_last;
               m_vld  = 1'b1;
               acc_q.delete();
            end
         end
      end
   end

   task automatic check_bit(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_cycle();
      check_bit("R6 in_ready", in_ready, !m_vld || out_ready);
      check_bit("R5 out_valid", out_valid, m_vld);
      if (m_vld) begin
         total++;
         if (out_data !== m_data) begin
            bad++;
            $display("FAIL R1 R4 R7 data act=%h exp=%h t=%0t", out_data, m_data, $time);
         end
         total++;
         if (out_strb !== m_strb) begin
            bad++;
            $display("FAIL R3 R9 strb act=%b exp=%b t=%0t", out_strb, m_strb, $time);
         end
         check_bit("R2 last", out_last, m_last);
      end
   endtask

   task automatic add_packet(input int len);
      for (int k = 0; k < len; k++) begin
         seq++;
         src_q.push_back({(k == len - 1), BYTE_W'((seq % 255) + 1)});
      end
   endtask

   task automatic run(input bit stall);
      int cyc = 0;
      while (src_q.size() != 0 || m_vld || in_valid) begin
         @(negedge clk);
         compare_cycle();
         if (took && src_q.size() != 0) void'(src_q.pop_front());
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
         in_valid  = (src_q.size() != 0) && (!stall || lfsr[5] || lfsr[7]);
         if (src_q.size() != 0) {in_last, in_byte} = src_q[0];
         else {in_last, in_byte} = '0;
         cyc++;
         if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired t=%0t", $time);
            break;
         end
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check_bit("R8 out_valid", out_valid, 1'b0);
      check_bit("R8 in_ready", in_ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R8 out_valid after release", out_valid, 1'b0);
      // directed: full word, two words, R9 single byte, partial tails
      add_packet(4);
      add_packet(8);
      add_packet(1);
      add_packet(1);
      add_packet(3);
      add_packet(5);
      add_packet(2);
      add_packet(3);
      add_packet(7);
      run(1'b0);
      // backpressure and gaps
      for (int p = 0; p < 40; p++) add_packet((p % 9) + 1);
      run(1'b1);
      repeat (3) begin
         @(negedge clk);
         compare_cycle();
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule